// File: doc/BRIEF.md
# Bunch-Train Pixel Hit Timestamp Buffer

This block is the digital back end of a binary-readout pixel sensor. Between a train-start and a train-end pulse it counts crossing strobes. At every strobe it writes the current crossing number into the small local memory of each pixel whose comparator bit is set. No trigger is used. While the train runs, nothing leaves the block.

Once the train has closed, a scanner walks the pixels over one shared read bus and drains every stored entry onto a valid/ready output stream. Each word carries the pixel address, the crossing number and that pixel's overflow flag. A final marker word carries the number of hit words that were sent. When the marker is accepted, every pixel memory is wiped and the block waits for the next train. The inter-train gap is assumed to be long enough for the whole drain to finish.

Top module: `hit_train_buffer`

## Requirements
- R1: After reset, out_valid and out_mark are low and every pixel memory is empty.
- R2: The crossing counter restarts at 0 on an accepted train_start. Each xing strobe during a train stores the counter value into every pixel whose hit bit is 1. The counter then advances by one.
- R3: xing strobes, hit bits and train_end pulses that arrive outside an active train change nothing and produce no output.
- R4: Each pixel keeps at most DEPTH entries. Later hits on that pixel are dropped, and its overflow flag (out_ovf = 1) is set on every word that pixel emits.
- R5: The drain visits pixels in ascending address order and emits each pixel's entries in the order they were stored. A pixel with no entries emits no word.
- R6: While out_valid is high and out_ready is low, out_valid and all output fields hold their values.
- R7: After the last hit word, a single word with out_mark = 1 is sent. Its out_total equals the number of hit words sent in that drain.
- R8: When the marker is accepted, all pixel entries and overflow flags are cleared, so the next train's drain contains only that train's hits.
- R9: A xing strobe in the same cycle as train_end is still recorded, and it is the train's last crossing.
- R10: A train_start during a drain is ignored: the block returns to idle after the marker and does not open a train.
- R11: The crossing number saturates at 2^TSW-1. Later crossings in the same train store that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| train_start | input | 1 | Opens a train when the block is idle |
| train_end | input | 1 | Closes the active train and starts the drain |
| xing | input | 1 | Crossing strobe |
| hit | input | NPIX | Per-pixel comparator bits, sampled with xing |
| out_ready | input | 1 | Consumer accepts the current word |
| out_valid | output | 1 | Output word is present |
| out_mark | output | 1 | Word is the end-of-drain marker |
| out_addr | output | AW | Pixel address of a hit word |
| out_ovf | output | 1 | Overflow flag of that pixel |
| out_xnum | output | TSW | Stored crossing number |
| out_total | output | CW | Hit-word count, valid on the marker |

## Verification
Two events can fall in the same clock edge: the closing of a train and the recording of a crossing. The bench provokes this by driving train_end together with a xing that hits one pixel. It then expects that pixel's last drained word to carry the final crossing number. A second collision is a train_start pulse issued in the middle of a drain while the output is being throttled. That case is judged by showing that the drain order and the marker are unchanged, and that a later strobe-plus-end pair produces no output.

// File: rtl/htb_pkg.sv
// Package: shared state type and width helper for the hit timestamp buffer.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package htb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRAIN = 2'd1,
        ST_DRAIN = 2'd2,
        ST_MARK  = 2'd3
    } htb_state_e;

    // Minimum width able to index n items; never below one bit.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/htb_xing_count.sv
// Module: crossing-number counter for one train.
// Restarts at zero on restart and advances once per accepted strobe.
// Saturates at the all-ones value.
// Assumes: restart and step are never both requested for the same crossing.
module htb_xing_count #(
    parameter int unsigned TSW = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic           step,
    output logic [TSW-1:0] xnum
);
    localparam logic [TSW-1:0] XMAX = '1;

    // Purpose: hold the crossing number of the next strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            xnum <= '0;
        else if (restart)
            xnum <= '0;
        else if (step && (xnum != XMAX))
            xnum <= xnum + 1'b1;
    end

    // R11
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xnum == XMAX && !restart) |=> (xnum == XMAX));

endmodule

// File: rtl/htb_pix_mem.sv
// Module: timestamp memory of one pixel.
// Stores up to DEPTH crossing numbers in arrival order and raises a sticky
// overflow flag when a hit finds the memory full.
// The read port is a shared-bus slice selected by rd_idx.
// Assumes: clr and wr are never high in the same cycle (clr only in drain).
module htb_pix_mem #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned TSW   = 13,
    parameter int unsigned KW    = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic           clr,
    input  logic [TSW-1:0] xnum,
    input  logic [KW-1:0]  rd_idx,
    output logic [KW-1:0]  cnt,
    output logic           ovf,
    output logic [TSW-1:0] rd_xnum
);
    localparam logic [KW-1:0] FULL = KW'(DEPTH);

    logic [TSW-1:0] slot [DEPTH];

    // Purpose: write the crossing number into the next free slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) slot[e] <= '0;
        end else if (wr && (cnt != FULL)) begin
            for (int e = 0; e < DEPTH; e++)
                if (cnt == KW'(e)) slot[e] <= xnum;
        end
    end

    // Purpose: track fill level and overflow; wipe both on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (wr) begin
            if (cnt != FULL) cnt <= cnt + 1'b1;
            else             ovf <= 1'b1;
        end
    end

    // Purpose: select the slot addressed by the shared read index.
    always_comb begin
        rd_xnum = '0;
        for (int e = 0; e < DEPTH; e++)
            if (rd_idx == KW'(e)) rd_xnum = slot[e];
    end

    // R4
    ovf_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> (cnt == FULL));

    // R3
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !clr) |=> ($stable(cnt) && $stable(ovf)));

    // R8
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && !ovf));

endmodule

// File: rtl/htb_ctrl.sv
// Module: train/drain sequencer and readout scanner.
// Tracks idle, train, drain and marker phases.
// Steps a pixel pointer and an entry index over the shared read bus.
// Presents words on a valid/ready stream and counts the words accepted.
// Assumes: sel_* inputs reflect the pixel addressed by pix in the same cycle.
module htb_ctrl
    import htb_pkg::*;
#(
    parameter int unsigned NPIX  = 16,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned TSW   = 13,
    parameter int unsigned AW    = 4,
    parameter int unsigned KW    = 3,
    parameter int unsigned CW    = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           train_start,
    input  logic           train_end,
    input  logic [KW-1:0]  sel_cnt,
    input  logic [TSW-1:0] sel_xnum,
    input  logic           sel_ovf,
    input  logic           out_ready,
    output logic           in_train,
    output logic           restart,
    output logic           clr,
    output logic [AW-1:0]  pix,
    output logic [KW-1:0]  idx,
    output logic           out_valid,
    output logic           out_mark,
    output logic [AW-1:0]  out_addr,
    output logic           out_ovf,
    output logic [TSW-1:0] out_xnum,
    output logic [CW-1:0]  out_total
);
    localparam logic [AW-1:0] LASTPIX = AW'(NPIX - 1);

    htb_state_e     st;
    logic [CW-1:0]  total;
    logic           last_entry;
    logic           pix_done;

    assign last_entry = (KW'(idx + 1'b1) == sel_cnt);
    assign pix_done   = (sel_cnt == '0) || (out_ready && last_entry);

    // Purpose: phase sequencing, scan pointers and accepted-word count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            pix   <= '0;
            idx   <= '0;
            total <= '0;
        end else begin
            case (st)
                ST_IDLE: if (train_start) st <= ST_TRAIN;
                ST_TRAIN: if (train_end) begin
                    st    <= ST_DRAIN;
                    pix   <= '0;
                    idx   <= '0;
                    total <= '0;
                end
                ST_DRAIN: begin
                    if (out_valid && out_ready) total <= total + 1'b1;
                    if (pix_done) begin
                        idx <= '0;
                        if (pix == LASTPIX) st  <= ST_MARK;
                        else                pix <= pix + 1'b1;
                    end else if (out_ready) begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_MARK: if (out_ready) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Purpose: control strobes to the counter and pixel memories.
    always_comb begin
        in_train = (st == ST_TRAIN);
        restart  = (st == ST_IDLE) && train_start;
        clr      = (st == ST_MARK) && out_ready;
    end

    // Purpose: drive the output word from the scan state and the read bus.
    always_comb begin
        out_valid = ((st == ST_DRAIN) && (sel_cnt != '0)) || (st == ST_MARK);
        out_mark  = (st == ST_MARK);
        out_addr  = (st == ST_DRAIN) ? pix      : '0;
        out_xnum  = (st == ST_DRAIN) ? sel_xnum : '0;
        out_ovf   = (st == ST_DRAIN) ? sel_ovf  : 1'b0;
        out_total = (st == ST_MARK)  ? total    : '0;
    end

    // R6
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_mark) &&
            $stable(out_addr) && $stable(out_xnum) && $stable(out_ovf) &&
            $stable(out_total)));

    // R5
    scan_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DRAIN && $past(st) == ST_DRAIN) |-> (pix >= $past(pix)));

    // R7
    mark_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mark) |-> (pix == LASTPIX));

    // R10
    no_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MARK && out_ready) |=> (st == ST_IDLE));

endmodule

// File: rtl/hit_train_buffer.sv
// Module: top of the bunch-train pixel hit timestamp buffer.
// Holds one timestamp memory per pixel and one crossing counter.
// A sequencer drains all pixels over a shared read bus onto a valid/ready stream.
// Assumes: hit is sampled only together with xing; one global threshold
// upstream produces the hit bits.
module hit_train_buffer
    import htb_pkg::*;
#(
    parameter int unsigned NPIX  = 16,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned TSW   = 13,
    localparam int unsigned AW   = idx_bits(NPIX),
    localparam int unsigned KW   = idx_bits(DEPTH + 1),
    localparam int unsigned CW   = idx_bits(NPIX * DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            train_start,
    input  logic            train_end,
    input  logic            xing,
    input  logic [NPIX-1:0] hit,
    input  logic            out_ready,
    output logic            out_valid,
    output logic            out_mark,
    output logic [AW-1:0]   out_addr,
    output logic            out_ovf,
    output logic [TSW-1:0]  out_xnum,
    output logic [CW-1:0]   out_total
);
    logic           in_train, restart, clr;
    logic [AW-1:0]  pix;
    logic [KW-1:0]  idx;
    logic [TSW-1:0] xnum;
    logic           step;

    logic [KW-1:0]  cnt_a  [NPIX];
    logic [TSW-1:0] rdx_a  [NPIX];
    logic           ovf_a  [NPIX];

    logic [KW-1:0]  sel_cnt;
    logic [TSW-1:0] sel_xnum;
    logic           sel_ovf;

    assign step = in_train && xing;

    htb_xing_count #(.TSW(TSW)) u_count (
        .clk(clk), .rst_n(rst_n), .restart(restart), .step(step), .xnum(xnum)
    );

    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        htb_pix_mem #(.DEPTH(DEPTH), .TSW(TSW), .KW(KW)) u_mem (
            .clk(clk), .rst_n(rst_n),
            .wr(step && hit[p]), .clr(clr),
            .xnum(xnum), .rd_idx(idx),
            .cnt(cnt_a[p]), .ovf(ovf_a[p]), .rd_xnum(rdx_a[p])
        );
    end

    // Purpose: shared read bus, select the pixel addressed by the scanner.
    always_comb begin
        sel_cnt  = '0;
        sel_xnum = '0;
        sel_ovf  = 1'b0;
        for (int p = 0; p < NPIX; p++) begin
            if (pix == AW'(p)) begin
                sel_cnt  = cnt_a[p];
                sel_xnum = rdx_a[p];
                sel_ovf  = ovf_a[p];
            end
        end
    end

    htb_ctrl #(
        .NPIX(NPIX), .DEPTH(DEPTH), .TSW(TSW), .AW(AW), .KW(KW), .CW(CW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .train_start(train_start), .train_end(train_end),
        .sel_cnt(sel_cnt), .sel_xnum(sel_xnum), .sel_ovf(sel_ovf),
        .out_ready(out_ready),
        .in_train(in_train), .restart(restart), .clr(clr),
        .pix(pix), .idx(idx),
        .out_valid(out_valid), .out_mark(out_mark), .out_addr(out_addr),
        .out_ovf(out_ovf), .out_xnum(out_xnum), .out_total(out_total)
    );

    // R2
    store_in_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && |hit) |-> !out_valid);

endmodule

// File: tb/hit_train_buffer_tb.sv
// Bench: drives trains with computed hit patterns, drains with throttled
// ready, and compares each word against an arithmetic model.
module hit_train_buffer_tb;
    localparam int NP = 16;
    localparam int DP = 4;
    localparam int TW = 13;
    localparam int AW = 4;
    localparam int CW = 7;
    localparam int XMAX = (1 << TW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic train_start = 1'b0, train_end = 1'b0, xing = 1'b0, out_ready = 1'b0;
    logic [NP-1:0] hit = '0;
    logic out_valid, out_mark, out_ovf;
    logic [AW-1:0] out_addr;
    logic [TW-1:0] out_xnum;
    logic [CW-1:0] out_total;

    always #4 clk = ~clk;

    hit_train_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .train_start(train_start), .train_end(train_end),
        .xing(xing), .hit(hit), .out_ready(out_ready), .out_valid(out_valid),
        .out_mark(out_mark), .out_addr(out_addr), .out_ovf(out_ovf),
        .out_xnum(out_xnum), .out_total(out_total)
    );

    int n_chk = 0, n_bad = 0;
    int mcnt [NP];
    int mx   [NP][DP];
    bit movf [NP];
    int mcur = 0, mstate = 0;
    int rp [80]; int rx [80]; int ro [80]; int rn = 0; int rtot = -1;
    logic [7:0] lfsr = 8'h5a;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int p = 0; p < NP; p++) begin mcnt[p] = 0; movf[p] = 0; end
    endtask

    task automatic do_start();
        train_start = 1'b1;
        if (mstate == 0) begin mstate = 1; mcur = 0; end
        @(negedge clk); train_start = 1'b0;
    endtask

    task automatic do_xing(input logic [NP-1:0] h, input bit with_end);
        xing = 1'b1; hit = h; train_end = with_end;
        if (mstate == 1) begin
            for (int p = 0; p < NP; p++) if (h[p]) begin
                if (mcnt[p] < DP) begin mx[p][mcnt[p]] = mcur; mcnt[p]++; end
                else movf[p] = 1;
            end
            mcur = (mcur < XMAX) ? mcur + 1 : XMAX;
            if (with_end) mstate = 2;
        end
        @(negedge clk); xing = 1'b0; hit = '0; train_end = 1'b0;
    endtask

    task automatic do_end();
        train_end = 1'b1;
        if (mstate == 1) mstate = 2;
        @(negedge clk); train_end = 1'b0;
    endtask

    // Drain with throttled (rmode=1) or constant ready; compare to model (R5, R7).
    task automatic drain(input int rmode, input bit pulse_start);
        int ep [80]; int ex [80]; int eo [80]; int en = 0;
        bit stall = 0, done = 0;
        logic [AW-1:0] pa; logic [TW-1:0] px; logic pm;
        for (int p = 0; p < NP; p++)
            for (int i = 0; i < mcnt[p]; i++) begin
                ep[en] = p; ex[en] = mx[p][i]; eo[en] = movf[p]; en++;
            end
        rn = 0; rtot = -1;
        for (int cyc = 0; cyc < 4000 && !done; cyc++) begin
            if (stall)
                chk(out_valid && out_addr == pa && out_xnum == px && out_mark == pm,
                    "R6", "held word addr", out_addr, pa);
            train_start = (pulse_start && cyc == 3);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = (rmode == 1) ? (lfsr[0] | lfsr[3]) : 1'b1;
            stall = out_valid && !out_ready;
            pa = out_addr; px = out_xnum; pm = out_mark;
            if (out_valid && out_ready) begin
                if (out_mark) begin
                    rtot = out_total; done = 1;
                end else begin
                    if (rn < en)
                        chk(out_addr == ep[rn] && out_xnum == ex[rn] && out_ovf == eo[rn],
                            "R5", "word addr/xnum", {out_addr, out_xnum},
                            {ep[rn][AW-1:0], ex[rn][TW-1:0]});
                    else
                        chk(0, "R5", "extra word addr", out_addr, -1);
                    if (rn < 80) begin
                        rp[rn] = out_addr; rx[rn] = out_xnum; ro[rn] = out_ovf; rn++;
                    end
                end
            end
            @(negedge clk);
        end
        train_start = 1'b0; out_ready = 1'b0;
        chk(done, "R7", "marker seen", done, 1);
        chk(rn == en, "R7", "word count", rn, en);
        chk(rtot == en, "R7", "marker total", rtot, en);
        model_clear(); mstate = 0;
    endtask

    function automatic int find_x(input int p, input int k);
        int seen = 0;
        for (int i = 0; i < rn; i++) if (rp[i] == p) begin
            if (seen == k) return rx[i];
            seen++;
        end
        return -1;
    endfunction

    function automatic int count_pix(input int p);
        int c = 0;
        for (int i = 0; i < rn; i++) if (rp[i] == p) c++;
        return c;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [NP-1:0] h;
        bit quiet;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!out_valid && !out_mark, "R1", "valid after reset", out_valid, 0);

        // R3: strobes and end outside a train are ignored
        do_xing('1, 1'b0); do_xing('1, 1'b1); do_end();
        quiet = 1;
        for (int c = 0; c < 6; c++) begin out_ready = 1'b1; if (out_valid) quiet = 0; @(negedge clk); end
        chk(quiet, "R3", "output while idle", !quiet, 0);

        // Train A: sweep pattern, overflow on pixels 0,1, none on 15
        do_start();
        for (int c = 0; c < 10; c++) begin
            for (int p = 0; p < NP; p++)
                h[p] = (p != 15) && (p < 2 || ((p + c) % 3 == 0));
            do_xing(h, 1'b0);
        end
        do_xing(16'h0004, 1'b1);   // R9: strobe together with end
        drain(1, 1'b0);
        chk(find_x(3, 0) == 0, "R2", "first crossing number", find_x(3, 0), 0);
        chk(find_x(4, 1) == 5, "R2", "pixel4 second crossing", find_x(4, 1), 5);
        chk(count_pix(0) == DP && ro[0] == 1, "R4", "pixel0 capped words", count_pix(0), DP);
        chk(find_x(1, 3) == 3, "R4", "pixel1 last kept", find_x(1, 3), 3);
        chk(count_pix(15) == 0, "R5", "empty pixel words", count_pix(15), 0);
        chk(find_x(2, 3) == 10, "R9", "end-cycle crossing", find_x(2, 3), 10);

        // Train B: few hits, start pulsed mid-drain
        do_start();
        do_xing(16'h0020, 1'b0);
        do_xing(16'h0000, 1'b0);
        do_xing(16'h8001, 1'b0);
        do_end();
        drain(1, 1'b1);
        chk(rn == 3 && find_x(0, 0) == 2, "R8", "cleared before train", find_x(0, 0), 2);
        chk(rn > 0 && ro[0] == 0, "R8", "overflow cleared", ro[0], 0);
        do_xing('1, 1'b1);
        quiet = 1;
        for (int c = 0; c < 8; c++) begin out_ready = 1'b1; if (out_valid) quiet = 0; @(negedge clk); end
        chk(quiet, "R10", "start during drain ignored", !quiet, 0);

        // Train C: saturation of crossing number
        do_start();
        do_xing(16'h0001, 1'b0);
        for (int c = 1; c < XMAX + 3; c++) do_xing('0, 1'b0);
        do_xing('1, 1'b0);
        do_end();
        drain(0, 1'b0);
        chk(find_x(0, 1) == XMAX, "R11", "saturated pixel0", find_x(0, 1), XMAX);
        chk(find_x(7, 0) == XMAX, "R11", "saturated pixel7", find_x(7, 0), XMAX);

        // Train D: every pixel full and overflowed
        do_start();
        for (int c = 0; c < 6; c++) do_xing('1, 1'b0);
        do_end();
        drain(1, 1'b0);
        chk(rtot == NP * DP, "R7", "full total", rtot, NP * DP);
        chk(ro[rn-1] == 1 && rx[rn-1] == 3, "R4", "last word overflow", ro[rn-1], 1);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule